// File: doc/BRIEF.md
# Extended Stack Pointer with Programmable Base

This block keeps the 11-bit stack pointer that addresses a 2 KB extended RAM. Software sees the pointer as two byte registers. The low register holds pointer bits [7:0]. The high register holds pointer bits [10:8] in its bits [2:0] and a 3-bit base field in its bits [5:3]. The base field supplies the three most significant bits of the lowest stack address, so the stack region starts at `base * 0x100` and runs to the top of RAM. When a push moves past 0x7FF, the pointer returns to that programmed base and not to zero.

A CPU core drives the block with register writes and with push and pop strobes. A push pre-increments the pointer, so the RAM write uses the new address. A pop post-decrements it, so the read uses the current address. Each strobe moves the pointer by one byte in one clock.

While protection is enabled, the block refuses any register write that would leave the pointer below the stack base. It then emits a one-cycle pulse so that an external monitor can record the attempt. The block also drives the current base address for that monitor.

Top module: `ext_stack_ptr`

## Requirements
- R1: After a synchronous reset, the pointer is 0x107, the base field is 001b (base address 0x100), the low register reads 0x07, the high register reads 0x09, and `bottom_viol` is low.
- R2: A push (with `push`=1, `pop`=0 and no register write) below 0x7FF raises the pointer by one on the next clock.
- R3: A pop (with `pop`=1, `push`=0 and no register write) lowers the pointer by one on the next clock, modulo 2048. 0x000 becomes 0x7FF, and a pop may take the pointer below the base.
- R4: A push while the pointer is 0x7FF loads the pointer with the base address (base field placed in bits [10:8], zeros below).
- R5: A write with `reg_sel`=0 replaces pointer bits [7:0] with `reg_wdata`. A write with `reg_sel`=1 loads pointer bits [10:8] from `reg_wdata[2:0]` and the base field from `reg_wdata[5:3]`. `reg_wdata[7:6]` is ignored. `hi_rd` returns {2'b00, base, pointer[10:8]} and `lo_rd` returns pointer[7:0].
- R6: With `prot_en`=1, a low write whose resulting pointer lies below the current base address is discarded.
- R7: With `prot_en`=1, a high write is discarded whole (both base and pointer kept) when the resulting pointer lies below the current base address or below the newly written base address. This covers a write that lowers the base and also moves the pointer under the old base.
- R8: With `prot_en`=0, every register write is accepted and `bottom_viol` stays low.
- R9: A register write takes priority over push and pop in the same cycle. Push and pop together, without a write, leave the pointer unchanged.
- R10: `stack_base` always equals the base field shifted into bits [10:8], and it changes only through an accepted high write or reset.
- R11: `bottom_viol` is high for exactly the one cycle that follows a discarded write and is low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_en | input | 1 | Enables the below-base write check |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the low register, 1 selects the high register |
| reg_wdata | input | 8 | Write data |
| push | input | 1 | Pre-increment request |
| pop | input | 1 | Post-decrement request |
| sp_addr | output | 11 | Current stack pointer |
| stack_base | output | 11 | Current stack base address |
| lo_rd | output | 8 | Low register read value |
| hi_rd | output | 8 | High register read value |
| bottom_viol | output | 1 | One-cycle pulse after a discarded write |

## Verification
The bench builds the block with its default reset values: pointer 0x107 and base field 001b. From that state, writes with protection off can reach every base from 0x000 to 0x700. The pointer can then be placed at 0x7FF and at 0x000, so the wrap to base and the decrement wrap are exercised at two different bases. The bench also lowers and raises the base in single high writes with protection on, which reaches both the old-base and the new-base rejection conditions. A random phase then mixes writes, strobes and protection settings against the behavioural model.

// File: rtl/xsp_pkg.sv
package xsp_pkg;

    localparam int SP_W   = 11;
    localparam int LO_W   = 8;
    localparam int HI_W   = SP_W - LO_W;
    localparam int BASE_W = 3;
    localparam int REG_W  = 8;
    localparam int PAD_W  = REG_W - BASE_W - HI_W;

    typedef logic [SP_W-1:0]   sp_t;
    typedef logic [BASE_W-1:0] base_t;
    typedef logic [REG_W-1:0]  reg_t;

    localparam sp_t SP_TOP = '1;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_PUSH,
        OP_POP,
        OP_WRITE
    } op_e;

    typedef struct packed {
        logic hi;
        reg_t data;
    } wr_t;

    typedef struct packed {
        sp_t   sp;
        base_t base;
        logic  reject;
    } cand_t;

    function automatic sp_t base_to_addr(base_t f);
        return {f, {(SP_W-BASE_W){1'b0}}};
    endfunction

    function automatic op_e decode_op(logic wr, logic inc, logic dec);
        if (wr)
            return OP_WRITE;
        else if (inc && !dec)
            return OP_PUSH;
        else if (dec && !inc)
            return OP_POP;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/xsp_step.sv
module xsp_step
    import xsp_pkg::*;
(
    input  sp_t   cur,
    input  base_t base,
    input  op_e   op,
    output sp_t   nxt
);

    always_comb begin
        unique case (op)
            OP_PUSH: nxt = (cur == SP_TOP) ? base_to_addr(base) : cur + sp_t'(1);
            OP_POP:  nxt = cur - sp_t'(1);
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/xsp_guard.sv
module xsp_guard
    import xsp_pkg::*;
(
    input  sp_t   cur,
    input  base_t base,
    input  wr_t   wr,
    input  logic  prot,
    output cand_t cand
);

    logic below_old;
    logic below_new;

    always_comb begin
        if (wr.hi) begin
            cand.sp   = {wr.data[HI_W-1:0], cur[LO_W-1:0]};
            cand.base = wr.data[HI_W+BASE_W-1:HI_W];
        end else begin
            cand.sp   = {cur[SP_W-1:LO_W], wr.data};
            cand.base = base;
        end
        below_old   = cand.sp < base_to_addr(base);
        below_new   = cand.sp < base_to_addr(cand.base);
        cand.reject = prot & (below_old | below_new);
    end

endmodule

// File: rtl/ext_stack_ptr.sv
module ext_stack_ptr
    import xsp_pkg::*;
#(
    parameter sp_t   RESET_SP   = 11'h107,
    parameter base_t RESET_BASE = 3'b001
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prot_en,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             push,
    input  logic             pop,
    output logic [SP_W-1:0]  sp_addr,
    output logic [SP_W-1:0]  stack_base,
    output logic [REG_W-1:0] lo_rd,
    output logic [REG_W-1:0] hi_rd,
    output logic             bottom_viol
);

    sp_t   sp_q;
    base_t base_q;
    logic  viol_q;
    op_e   op;
    wr_t   wr;
    cand_t cand;
    sp_t   step_sp;

    assign op      = decode_op(reg_wr, push, pop);
    assign wr.hi   = reg_sel;
    assign wr.data = reg_wdata;

    xsp_step u_step (
        .cur  (sp_q),
        .base (base_q),
        .op   (op),
        .nxt  (step_sp)
    );

    xsp_guard u_guard (
        .cur  (sp_q),
        .base (base_q),
        .wr   (wr),
        .prot (prot_en),
        .cand (cand)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q   <= RESET_SP;
            base_q <= RESET_BASE;
            viol_q <= 1'b0;
        end else if (op == OP_WRITE) begin
            viol_q <= cand.reject;
            if (!cand.reject) begin
                sp_q   <= cand.sp;
                base_q <= cand.base;
            end
        end else begin
            viol_q <= 1'b0;
            sp_q   <= step_sp;
        end
    end

    assign sp_addr     = sp_q;
    assign stack_base  = base_to_addr(base_q);
    assign lo_rd       = sp_q[LO_W-1:0];
    assign hi_rd       = {{PAD_W{1'b0}}, base_q, sp_q[SP_W-1:LO_W]};
    assign bottom_viol = viol_q;

endmodule

// File: rtl/ext_stack_ptr_chk.sv
module ext_stack_ptr_chk
    import xsp_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic prot_en,
    input logic reg_wr,
    input logic push,
    input logic pop,
    input sp_t  sp_addr,
    input sp_t  stack_base,
    input logic bottom_viol
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sp_addr == 11'h107 && stack_base == 11'h100 && !bottom_viol)); // R1

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && push && !pop && sp_addr != SP_TOP) |=> (sp_addr == sp_t'($past(sp_addr) + 1))); // R2

    AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && pop && !push) |=> (sp_addr == sp_t'($past(sp_addr) - 1))); // R3

    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && push && !pop && sp_addr == SP_TOP) |=> (sp_addr == $past(stack_base))); // R4

    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        bottom_viol |-> (sp_addr == $past(sp_addr) && stack_base == $past(stack_base))); // R7

    AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        bottom_viol |-> ($past(reg_wr) && $past(prot_en))); // R11

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && push && pop) |=> $stable(sp_addr)); // R9

    AST_BASE_STEADY: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_wr) |-> $stable(stack_base)); // R10

endmodule

bind ext_stack_ptr ext_stack_ptr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .prot_en     (prot_en),
    .reg_wr      (reg_wr),
    .push        (push),
    .pop         (pop),
    .sp_addr     (sp_addr),
    .stack_base  (stack_base),
    .bottom_viol (bottom_viol)
);

// File: tb/ext_stack_ptr_tb.sv
module ext_stack_ptr_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prot_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       push = 1'b0;
    logic       pop = 1'b0;
    logic [10:0] sp_addr;
    logic [10:0] stack_base;
    logic [7:0]  lo_rd;
    logic [7:0]  hi_rd;
    logic        bottom_viol;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    int m_sp;
    int m_base;
    int m_viol;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_stack_ptr u_dut (
        .clk         (clk),
        .rst         (rst),
        .prot_en     (prot_en),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .push        (push),
        .pop         (pop),
        .sp_addr     (sp_addr),
        .stack_base  (stack_base),
        .lo_rd       (lo_rd),
        .hi_rd       (hi_rd),
        .bottom_viol (bottom_viol)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "sp_addr", int'(sp_addr), m_sp);
        check(tag, "stack_base", int'(stack_base), m_base * 256);
        check(tag, "lo_rd", int'(lo_rd), m_sp % 256);
        check(tag, "hi_rd", int'(hi_rd), m_base * 8 + m_sp / 256);
        check(tag, "bottom_viol", int'(bottom_viol), m_viol);
    endtask

    // one clock: drive at negedge, predict, compare at the next negedge
    task automatic cyc(string tag, bit wr, bit sel, int data, bit pu, bit po, bit prot);
        int nsp;
        int nbase;
        int lo;
        reg_wr = wr; reg_sel = sel; reg_wdata = data[7:0];
        push = pu; pop = po; prot_en = prot;
        m_viol = 0;
        if (wr) begin
            lo = m_sp % 256;
            if (sel) begin
                nbase = (data / 8) % 8;
                nsp   = (data % 8) * 256 + lo;
            end else begin
                nbase = m_base;
                nsp   = (m_sp / 256) * 256 + (data % 256);
            end
            if (prot && (nsp < m_base * 256 || nsp < nbase * 256)) begin
                m_viol = 1;
            end else begin
                m_sp   = nsp;
                m_base = nbase;
            end
        end else if (pu && !po) begin
            m_sp = (m_sp == 2047) ? m_base * 256 : m_sp + 1;
        end else if (po && !pu) begin
            m_sp = (m_sp + 2047) % 2048;
        end
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_sp = 'h107; m_base = 1; m_viol = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all("R1");                       // reset state
        cyc("R1", 0, 0, 0, 0, 0, 0);             // idle keeps reset values

        cyc("R2", 0, 0, 0, 1, 0, 0);             // 0x108
        cyc("R2", 0, 0, 0, 1, 0, 1);             // 0x109
        cyc("R3", 0, 0, 0, 0, 1, 0);             // 0x108

        // protection off: base 000, pointer 0x000
        cyc("R8", 1, 1, 'h00, 0, 0, 0);
        cyc("R8", 1, 0, 'h00, 0, 0, 0);
        cyc("R3", 0, 0, 0, 0, 1, 0);             // 0x000 -> 0x7FF
        cyc("R4", 0, 0, 0, 1, 0, 0);             // wrap to base 0x000

        // base 110, then pointer 0x7FF with bits 7:6 set
        cyc("R5", 1, 1, 'h36, 0, 0, 0);
        cyc("R5", 1, 0, 'hFF, 0, 0, 0);
        cyc("R5", 1, 1, 'hF7, 0, 0, 0);          // hi_rd 0x37
        cyc("R4", 0, 0, 0, 1, 0, 0);             // wrap to 0x600
        cyc("R10", 0, 0, 0, 1, 0, 0);            // 0x601

        // protection on: high writes
        cyc("R7", 1, 1, 'h35, 0, 0, 1);          // 0x501 under base 0x600
        cyc("R11", 0, 0, 0, 0, 0, 1);            // pulse drops
        cyc("R7", 1, 1, 'h0D, 0, 0, 1);          // lower base, ptr under old base
        cyc("R7", 1, 1, 'h0E, 0, 0, 1);          // lower base, ptr stays 0x601: accepted
        cyc("R7", 1, 1, 'h3E, 0, 0, 1);          // ptr 0x601 under new base 0x700
        cyc("R7", 1, 1, 'h36, 0, 0, 1);          // raise base to 0x600: accepted
        cyc("R6", 1, 0, 'h00, 0, 0, 1);          // 0x600 == base: accepted
        cyc("R3", 0, 0, 0, 0, 1, 1);             // pop below base: 0x5FF
        cyc("R6", 1, 0, 'h10, 0, 0, 1);          // 0x510 under base: rejected
        cyc("R11", 1, 0, 'hFF, 0, 0, 1);         // 0x5FF still under base: rejected again
        cyc("R11", 0, 0, 0, 1, 0, 1);            // push 0x600, pulse clears

        cyc("R9", 1, 0, 'h40, 1, 0, 1);          // write wins over push
        cyc("R9", 1, 0, 'h20, 0, 1, 1);          // write wins over pop
        cyc("R9", 0, 0, 0, 1, 1, 1);             // push and pop together hold
        cyc("R8", 1, 1, 'h00, 0, 0, 0);          // unprotected: accepted, no pulse
        cyc("R8", 1, 0, 'h00, 0, 0, 0);

        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom);
            cyc("R9", (r % 5) == 0, r[3], int'($urandom % 256), r[4], r[5], r[6]);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule